// File: doc/BRIEF.md
# Packed Sample Pin Streamer

This block drives a parallel pin bus that feeds a resistor-ladder DAC. It reads 32-bit words from a show-ahead transmit FIFO and splits each word into fixed-width samples. It presents one sample per output update. An integer divider of the system clock sets the update rate. A slow rate therefore needs no longer sample table upstream.

The mode selects one of four single-channel widths (8, 10, 11 or 12 bits) or one of two dual-channel layouts (2 x 8 or 2 x 11 bits). In the dual layouts the second channel is wired with its bit order reversed, so that the most significant bits of both channels sit next to each other in the middle of the bus.

Mode and divider are captured only when `restart` is pulsed. Software fills the FIFO, sets the configuration and pulses `restart`. From then on the block streams by itself. It raises a sticky flag if it ever finds no sample ready when an update is due.

Top module: `pin_stream_unpacker`

## Requirements
- R1: After reset the block is idle. `pins` is zero, `underrun` is zero and `fifo_rd` stays low until `restart` is seen. A `restart` cycle captures `cfg_mode` and `cfg_div_m1`, drives `pins` to zero, clears `underrun` and discards any partly used word. Changes to `cfg_mode` or `cfg_div_m1` without `restart` have no effect.
- R2: The programmed period is D = `cfg_div_m1` + 1 (1 to 65536). If `restart` is captured at clock edge k, `pins` may change only at edges k+D, k+2D, and so on, and at every such edge a new sample is shown when one is available.
- R3: The effective period is never shorter than a floor set by the mode. The floor is 2 clocks when a word holds two samples and 3 clocks when a word holds one sample. A programmed D below the floor is raised to the floor.
- R4: Mode codes are 0 = 8-bit (4 samples per word), 1 = 10-bit (3 per word), 2 = 11-bit (2 per word), 3 = 12-bit (2 per word), 4 = dual 8-bit (2 per word, 16 bits each), 5 = dual 11-bit (1 per word, 22 bits). With S bits per sample, sample i of a word is bits [(i+1)S-1 : iS]. Samples are shown in increasing i. Word bits above the last sample are ignored.
- R5: In the single-channel modes, sample bit j drives pin j. All higher pins are zero.
- R6: In the dual modes with channel width W, channel A is the low W bits of the sample and drives pins 0 to W-1, with its LSB on pin 0. Channel B is the next W bits and drives pins 11 to 10+W, with its MSB on pin 11 and its LSB on pin 10+W. All other pins are zero.
- R7: `fifo_rd` is high only while running, outside a `restart` cycle, with the FIFO not empty and no sample of the held word left to show. One word is taken per word used up, at most one word ahead of the output.
- R8: If an update is due and no sample is held and the FIFO is empty, `pins` keeps its value and `underrun` goes high. `underrun` stays high until the next `restart`. Output resumes from the first word that arrives afterwards.
- R9: Mode codes 6 and 7 behave exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Capture configuration and start streaming from a fresh word |
| cfg_mode | input | 3 | Packing and pin layout code |
| cfg_div_m1 | input | 16 | Update period minus one, in clocks |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rdata | input | 32 | Word at the FIFO head, valid while not empty |
| fifo_rd | output | 1 | Pop the FIFO head at this clock edge |
| pins | output | 22 | Parallel bus to the DAC ladder |
| underrun | output | 1 | Sticky: an update found no sample |

## Verification
A slot counter that skips or repeats shows up at the first affected update as a wrong value on `pins`, and the FIFO pop falls one update early or late. A divider that is one count off moves the very next pin change by one clock. A stale held-word flag shows up as a pop while a word is still being shown, or as a missing pop once a word is used up. Either appears within one word's worth of updates. A wrong pin map shows up on the first sample of a dual mode, because channel B's LSB lands on pin 21 and not pin 11.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int WORD_W = 32;
  localparam int PIN_W  = 22;
  localparam int DIV_W  = 16;
  localparam int MODE_W = 3;
  localparam int B_BASE = 11;

  localparam logic [MODE_W-1:0] M_S8  = 3'd0;
  localparam logic [MODE_W-1:0] M_S10 = 3'd1;
  localparam logic [MODE_W-1:0] M_S11 = 3'd2;
  localparam logic [MODE_W-1:0] M_S12 = 3'd3;
  localparam logic [MODE_W-1:0] M_D8  = 3'd4;
  localparam logic [MODE_W-1:0] M_D11 = 3'd5;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [PIN_W-1:0]  pins_t;
  typedef logic [DIV_W:0]    period_t;
  typedef logic [MODE_W-1:0] mode_t;

  function automatic mode_t norm_mode(input mode_t m);
    return (m > M_D11) ? M_S8 : m;
  endfunction

  function automatic logic [2:0] per_word(input mode_t m);
    case (m)
      M_S10:              return 3'd3;
      M_S11, M_S12, M_D8: return 3'd2;
      M_D11:              return 3'd1;
      default:            return 3'd4;
    endcase
  endfunction

  function automatic logic [4:0] stride(input mode_t m);
    case (m)
      M_S10:   return 5'd10;
      M_S11:   return 5'd11;
      M_S12:   return 5'd12;
      M_D8:    return 5'd16;
      M_D11:   return 5'd22;
      default: return 5'd8;
    endcase
  endfunction

  function automatic period_t eff_period(input mode_t m, input logic [DIV_W-1:0] m1);
    period_t d;
    period_t lo;
    d = period_t'(m1) + period_t'(1);
    case (per_word(m))
      3'd2:    lo = period_t'(2);
      3'd1:    lo = period_t'(3);
      default: lo = period_t'(1);
    endcase
    return (d < lo) ? lo : d;
  endfunction

  function automatic logic [5:0] bit_offset(input mode_t m, input logic [1:0] slot);
    return 6'(slot) * 6'(stride(m));
  endfunction

  function automatic pins_t place(input mode_t m, input word_t raw);
    pins_t p;
    p = '0;
    case (m)
      M_S10: p[9:0]  = raw[9:0];
      M_S11: p[10:0] = raw[10:0];
      M_S12: p[11:0] = raw[11:0];
      M_D8: begin
        p[7:0] = raw[7:0];
        for (int i = 0; i < 8; i++) p[B_BASE+i] = raw[15-i];
      end
      M_D11: begin
        p[10:0] = raw[10:0];
        for (int i = 0; i < 11; i++) p[B_BASE+i] = raw[21-i];
      end
      default: p[7:0] = raw[7:0];
    endcase
    return p;
  endfunction
endpackage

// File: rtl/pss_tick_gen.sv
module pss_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           enable,
  input  logic [DIV_W:0] period,
  output logic           tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W:0]   last_v;

  assign last_v = period - 1'b1;
  assign tick   = enable && !clear && ({1'b0, cnt_q} == last_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear || !enable)  cnt_q <= '0;
    else if (tick)              cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pss_word_slot.sv
module pss_word_slot
  import pss_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  run,
  input  logic  tick,
  input  mode_t mode,
  input  logic  fifo_empty,
  input  word_t fifo_rdata,
  output logic  fifo_rd,
  output logic  emit,
  output logic  starve,
  output word_t sample_raw
);
  word_t      word_q;
  logic       have_q;
  logic [1:0] slot_q;
  logic [2:0] spw;
  logic       tick_hit;
  logic       last;
  word_t      src;
  logic [1:0] src_slot;

  assign spw      = per_word(mode);
  assign tick_hit = run && tick;
  assign fifo_rd  = run && !clear && !have_q && !fifo_empty;
  assign emit     = tick_hit && (have_q || !fifo_empty);
  assign starve   = tick_hit && !have_q && fifo_empty;
  assign last     = ({1'b0, slot_q} == (spw - 3'd1));
  assign src      = have_q ? word_q : fifo_rdata;
  assign src_slot = have_q ? slot_q : 2'd0;
  assign sample_raw = src >> bit_offset(mode, src_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      have_q <= 1'b0;
      slot_q <= '0;
    end else if (clear) begin
      have_q <= 1'b0;
      slot_q <= '0;
    end else if (fifo_rd) begin
      word_q <= fifo_rdata;
      if (tick_hit) begin
        have_q <= (spw != 3'd1);
        slot_q <= 2'd1;
      end else begin
        have_q <= 1'b1;
        slot_q <= 2'd0;
      end
    end else if (tick_hit && have_q) begin
      if (last) begin
        have_q <= 1'b0;
        slot_q <= '0;
      end else begin
        slot_q <= slot_q + 2'd1;
      end
    end
  end
endmodule

// File: rtl/pin_stream_unpacker.sv
module pin_stream_unpacker
  import pss_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic [2:0]  cfg_mode,
  input  logic [15:0] cfg_div_m1,
  input  logic        fifo_empty,
  input  logic [31:0] fifo_rdata,
  output logic        fifo_rd,
  output logic [21:0] pins,
  output logic        underrun
);
  mode_t   mode_q;
  period_t div_q;
  logic    running;
  pins_t   pins_q;
  logic    under_q;

  logic    tick;
  logic    emit;
  logic    underrun_evt;
  word_t   sample_raw;

  pss_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (restart),
    .enable (running),
    .period (div_q),
    .tick   (tick)
  );

  pss_word_slot u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (restart),
    .run        (running),
    .tick       (tick),
    .mode       (mode_q),
    .fifo_empty (fifo_empty),
    .fifo_rdata (fifo_rdata),
    .fifo_rd    (fifo_rd),
    .emit       (emit),
    .starve     (underrun_evt),
    .sample_raw (sample_raw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_S8;
      div_q   <= period_t'(1);
      running <= 1'b0;
      pins_q  <= '0;
      under_q <= 1'b0;
    end else if (restart) begin
      mode_q  <= norm_mode(cfg_mode);
      div_q   <= eff_period(norm_mode(cfg_mode), cfg_div_m1);
      running <= 1'b1;
      pins_q  <= '0;
      under_q <= 1'b0;
    end else begin
      if (emit)         pins_q  <= place(mode_q, sample_raw);
      if (underrun_evt) under_q <= 1'b1;
    end
  end

  assign pins     = pins_q;
  assign underrun = under_q;
endmodule

// File: rtl/pss_checker.sv
module pss_checker
  import pss_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        restart,
  input logic        fifo_empty,
  input logic        fifo_rd,
  input logic [21:0] pins,
  input logic        underrun,
  input logic        tick,
  input logic        underrun_evt,
  input logic        running,
  input mode_t       mode_q
);
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!fifo_rd && pins == '0 && !underrun)); // R1

  AST_PINS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(pins)); // R2

  AST_TWO_PER_WORD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && per_word(mode_q) == 3'd2) |=> !tick); // R3

  AST_ONE_PER_WORD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && per_word(mode_q) == 3'd1) |=> !tick ##1 (!tick || $past(restart))); // R3

  AST_S8_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_S8) |-> pins[21:8] == '0); // R5

  AST_D8_GAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_D8) |-> (pins[10:8] == '0 && pins[21:19] == '0)); // R6

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty); // R7

  AST_NO_POP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !fifo_rd); // R7

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !restart) |=> underrun); // R8

  AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_evt && !restart) |=> ($stable(pins) && underrun)); // R8
endmodule

bind pin_stream_unpacker pss_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .restart      (restart),
  .fifo_empty   (fifo_empty),
  .fifo_rd      (fifo_rd),
  .pins         (pins),
  .underrun     (underrun),
  .tick         (tick),
  .underrun_evt (underrun_evt),
  .running      (running),
  .mode_q       (mode_q)
);

// File: tb/pin_stream_unpacker_test.sv
module pin_stream_unpacker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic [2:0]  cfg_mode = 3'd0;
  logic [15:0] cfg_div_m1 = 16'd0;
  logic        fifo_empty = 1'b1;
  logic [31:0] fifo_rdata = 32'd0;
  logic        fifo_rd;
  logic [21:0] pins;
  logic        underrun;

  pin_stream_unpacker uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cfg_mode(cfg_mode),
    .cfg_div_m1(cfg_div_m1), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
    .fifo_rd(fifo_rd), .pins(pins), .underrun(underrun)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  string tag = "R1";

  longint q[$];
  longint held[$];
  bit     pop_pending = 0;
  bit     m_run = 0;
  int     m_mode = 0;
  longint m_div = 1;
  longint m_cnt = 0;
  longint m_pins = 0;
  bit     m_under = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog (%s) got cycle %0d expected completion", tag, cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Requirement-level view of the modes (R4, R9)
  function automatic int s_bits(int m);
    case (m)
      1: return 10;
      2: return 11;
      3: return 12;
      4: return 16;
      5: return 22;
      default: return 8;
    endcase
  endfunction

  function automatic int chan_w(int m);
    if (m == 4) return 8;
    if (m == 5) return 11;
    return 0;
  endfunction

  function automatic longint floor_of(int m);
    int n;
    n = 32 / s_bits(m);
    if (n == 2) return 2;
    if (n == 1) return 3;
    return 1;
  endfunction

  function automatic longint pin_image(int m, longint v);
    int w;
    longint a, b, r;
    w = chan_w(m);
    if (w == 0) return v;
    a = v % (longint'(1) << w);
    b = v / (longint'(1) << w);
    r = a;
    for (int i = 0; i < w; i++)
      if ((b >> (w - 1 - i)) & 1) r += longint'(1) << (11 + i);
    return r;
  endfunction

  task automatic refresh();
    fifo_empty = (q.size() == 0);
    fifo_rdata = (q.size() > 0) ? 32'(q[0]) : 32'd0;
  endtask

  task automatic push(longint w);
    q.push_back(w);
    refresh();
  endtask

  task automatic check(string req, longint got, longint exp, string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic advance();
    bit exp_rd;
    bit t;
    int s, n;
    exp_rd = 0;
    if (restart) begin
      m_run = 1;
      m_mode = (cfg_mode > 5) ? 0 : int'(cfg_mode);
      m_div = longint'(cfg_div_m1) + 1;
      if (m_div < floor_of(m_mode)) m_div = floor_of(m_mode);
      m_cnt = 0;
      held.delete();
      m_pins = 0;
      m_under = 0;
    end else if (m_run) begin
      if (held.size() == 0 && q.size() > 0) begin
        exp_rd = 1;
        s = s_bits(m_mode);
        n = 32 / s;
        for (int i = 0; i < n; i++)
          held.push_back((q[0] >> (i * s)) % (longint'(1) << s));
      end
      t = (m_cnt == m_div - 1);
      m_cnt = t ? 0 : m_cnt + 1;
      if (t) begin
        if (held.size() > 0) m_pins = pin_image(m_mode, held.pop_front());
        else m_under = 1;
      end
    end
    check("R7", fifo_rd, exp_rd, "fifo_rd");
    pop_pending = exp_rd;
  endtask

  task automatic step();
    #1;
    advance();
    @(posedge clk);
    #1;
    if (pop_pending) begin
      void'(q.pop_front());
      pop_pending = 0;
    end
    refresh();
    @(negedge clk);
    check(tag, pins, m_pins, "pins");
    check("R8", underrun, m_under, "underrun");
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic start(int m, int m1);
    cfg_mode = 3'(m);
    cfg_div_m1 = 16'(m1);
    restart = 1'b1;
    step();
    restart = 1'b0;
  endtask

  initial begin
    // R1: reset and idle before any restart, FIFO already holding data
    tag = "R1";
    push(64'h11223344);
    @(negedge clk);
    check("R1", pins, 0, "pins in reset");
    check("R1", underrun, 0, "underrun in reset");
    rst_n = 1'b1;
    steps(6);
    check("R1", q.size(), 1, "fifo untouched while idle");
    q.delete();
    refresh();

    // R4 / R5: 8-bit, period 1, then drain into underrun, then resume
    tag = "R5";
    push(64'h44332211);
    push(64'h88776655);
    start(0, 0);
    steps(12);
    check("R8", underrun, 1, "underrun after drain");
    tag = "R8";
    push(64'hCCBBAA99);
    steps(8);

    // R2: 10-bit, period 4
    tag = "R2";
    push(64'hFFF12345);
    push(64'h3ABCDEF0);
    push(64'h0F0F0F0F);
    start(1, 3);
    steps(50);

    // R3: 11-bit with programmed period 1 raised to 2
    tag = "R3";
    push(64'hFFFFFFFF);
    push(64'h12345678);
    push(64'h00000000);
    start(2, 0);
    steps(20);

    // R4: 12-bit, period 3
    tag = "R4";
    push(64'hABCDE123);
    push(64'h00FFF001);
    start(3, 2);
    steps(20);

    // R6: dual 8-bit, period 2
    tag = "R6";
    push(64'h80010103);
    push(64'h0000A5C3);
    start(4, 1);
    steps(20);

    // R6: dual 11-bit, channel B LSB alone lands on pin 21; period raised to 3
    push(64'h00000800);
    push(64'hFFFFFFFF);
    push(64'h00000401);
    start(5, 0);
    steps(3);
    check("R6", pins, 22'h200000, "dual 11 B LSB on pin 21");
    steps(20);

    // R9: reserved code behaves as 8-bit
    tag = "R9";
    push(64'hDEADBEEF);
    start(7, 0);
    steps(10);

    // R1: config changes without restart ignored; restart drops partly used word
    tag = "R1";
    push(64'h04030201);
    push(64'h08070605);
    start(0, 0);
    cfg_mode = 3'd5;
    cfg_div_m1 = 16'd9;
    steps(3);
    cfg_mode = 3'd0;
    cfg_div_m1 = 16'd0;
    start(0, 0);
    steps(8);

    // R2: longest period, one update after 65536 clocks
    tag = "R2";
    push(64'h000000A7);
    start(0, 16'hFFFF);
    steps(65540);
    check("R2", pins, 22'h0000A7, "update at maximum period");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule